// File: doc/BRIEF.md
# Audio Sample Write Packer

This block sits between a byte-addressable register bus and the transmit FIFO of an audio port. Software may write a sample as several narrow bus writes or as one wide write into a 4-byte data window. The block collects the written bytes in a staging word. It pushes that word into the FIFO on the write that reaches the most significant byte of the selected sample length. After the push, the next sample starts again from an empty staging word.

A 2-bit length mode selects the sample length: 16, 20, 24 or 32 bits. Bytes that lie above the selected length are dropped. A write whose enabled bytes all fall in unused lanes leaves the block untouched. When the FIFO reports full at the moment a sample completes, the sample is discarded and a sticky overflow flag records the loss.

Top module: `abp_top`

## Requirements
- R1: The length mode encodes 00=16, 01=20, 10=24 and 11=32 bits. The top byte lane is 1, 2, 2 and 3 respectively. A write that enables the top lane completes the sample.
- R2: Enabled byte j of `wrData` (bits 8j+7..8j, with `wrBe[j]`) lands in byte lane `wrOffset`+j. Bytes that would land above lane 3 are dropped.
- R3: Bytes landing above the top lane are dropped. A write that reaches no used lane changes nothing: it neither pushes nor alters the staging word.
- R4: In a pushed word, every used lane that was not written since the previous push reads zero. The staging word is emptied after every completed sample.
- R5: `pushValid` is high for exactly the one cycle after the clock edge that accepts a completing write. `pushData` carries the word during that cycle. A completing write stores no byte into the following sample.
- R6: In 16-bit mode, `pushData[31:16]` is zero. In 20-bit and 24-bit modes, `pushData[31:24]` is zero.
- R7: A change of the length mode empties any partly assembled sample before the write of that cycle is merged.
- R8: If `fifoFull` is high on the edge that completes a sample, no push occurs and the sample is discarded. `overflow` is then set and stays set until reset.
- R9: Synchronous active-low reset clears `pushValid`, `overflow`, `pushData` and the staging word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Bus write strobe into the data window |
| wrOffset | input | 2 | Byte offset of the lowest written byte |
| wrBe | input | 4 | Byte enables, relative to `wrOffset` |
| wrData | input | 32 | Write data, right-aligned to `wrOffset` |
| lenMode | input | 2 | Sample length mode (00=16, 01=20, 10=24, 11=32 bits) |
| fifoFull | input | 1 | FIFO full flag |
| pushValid | output | 1 | One-cycle FIFO push strobe |
| pushData | output | 32 | Packed sample word |
| overflow | output | 1 | Sticky lost-sample flag |

## Verification
Every result is due one cycle after the edge that accepts a write: the push strobe, the pushed word and the overflow flag are all registered exactly once. The bench drives each write on a falling edge and holds it for one rising edge. It compares the outputs just after that rising edge against a byte-lane model kept in the bench. It then idles a cycle and checks that the push strobe has dropped. Ignored writes and mode flushes have no direct output. The bench therefore checks them through the content of the next pushed word.

// File: rtl/abp_pkg.sv
package abp_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam int OFF_W  = $clog2(LANES);

  typedef struct packed {
    logic [LANES-1:0] laneWr;  // lanes loaded this cycle
    logic             flush;   // empty staging before merge (mode change)
    logic             push;    // completed sample goes to FIFO
    logic             drop;    // completed sample discarded (FIFO full)
  } strobes_t;

  function automatic logic [OFF_W-1:0] topLane(input logic [1:0] mode);
    case (mode)
      2'b00:   topLane = OFF_W'(1);
      2'b11:   topLane = OFF_W'(3);
      default: topLane = OFF_W'(2);
    endcase
  endfunction

  function automatic logic [LANES-1:0] usedLanes(input logic [1:0] mode);
    for (int i = 0; i < LANES; i++) usedLanes[i] = (i <= int'(topLane(mode)));
  endfunction
endpackage

// File: rtl/abp_ctrl.sv
module abp_ctrl
  import abp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [OFF_W-1:0] wrOffset,
  input  logic [LANES-1:0] wrBe,
  input  logic [1:0]       lenMode,
  input  logic             fifoFull,
  output strobes_t         strb,
  output logic             pushValid,
  output logic             overflow
);
  logic [1:0]         lastMode;
  logic [2*LANES-1:0] wideBe;
  logic [LANES-1:0]   hitLanes;
  logic               complete;

  assign wideBe   = {{LANES{1'b0}}, wrBe} << wrOffset;
  assign hitLanes = wideBe[LANES-1:0] & usedLanes(lenMode);
  assign complete = wrEn && hitLanes[topLane(lenMode)];

  always_comb begin
    strb.laneWr = wrEn ? hitLanes : '0;
    strb.flush  = (lenMode != lastMode);
    strb.push   = complete && !fifoFull;
    strb.drop   = complete && fifoFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastMode  <= 2'b00;
      pushValid <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      lastMode  <= lenMode;
      pushValid <= strb.push;
      overflow  <= overflow | strb.drop;
    end
  end
endmodule

// File: rtl/abp_datapath.sv
module abp_datapath
  import abp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [OFF_W-1:0]  wrOffset,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] pushData
);
  logic [DATA_W-1:0]   stage;
  logic [DATA_W-1:0]   base;
  logic [DATA_W-1:0]   merged;
  logic [2*DATA_W-1:0] wideData;

  assign wideData = {{DATA_W{1'b0}}, wrData} << {wrOffset, 3'b000};
  assign base     = strb.flush ? '0 : stage;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*LANE_W +: LANE_W] =
      strb.laneWr[i] ? wideData[i*LANE_W +: LANE_W] : base[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage    <= '0;
      pushData <= '0;
    end else begin
      stage <= (strb.push || strb.drop) ? '0 : merged;
      if (strb.push) pushData <= merged;
    end
  end
endmodule

// File: rtl/abp_top.sv
module abp_top
  import abp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrOffset,
  input  logic [3:0]  wrBe,
  input  logic [31:0] wrData,
  input  logic [1:0]  lenMode,
  input  logic        fifoFull,
  output logic        pushValid,
  output logic [31:0] pushData,
  output logic        overflow
);
  strobes_t strb;

  abp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOffset(wrOffset), .wrBe(wrBe),
    .lenMode(lenMode), .fifoFull(fifoFull), .strb(strb),
    .pushValid(pushValid), .overflow(overflow)
  );

  abp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrOffset(wrOffset),
    .wrData(wrData), .pushData(pushData)
  );
endmodule

// File: rtl/abp_checker.sv
module abp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  wrOffset,
  input logic [3:0]  wrBe,
  input logic [1:0]  lenMode,
  input logic        fifoFull,
  input logic        pushValid,
  input logic [31:0] pushData,
  input logic        overflow
);
  a_r5_push_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> $past(wrEn));

  a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> !$past(fifoFull));

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(overflow) |-> overflow);

  a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && $past(lenMode) == 2'b00) |-> (pushData[31:16] == 16'h0));

  a_r6_mid_top_byte_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && ($past(lenMode) == 2'b01 || $past(lenMode) == 2'b10))
      |-> (pushData[31:24] == 8'h0));

  a_r1_full_write_pushes: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn) && !$past(fifoFull) && $past(wrBe) == 4'hF && $past(wrOffset) == 2'd0)
      |-> pushValid);
endmodule

bind abp_top abp_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOffset(wrOffset), .wrBe(wrBe),
  .lenMode(lenMode), .fifoFull(fifoFull), .pushValid(pushValid),
  .pushData(pushData), .overflow(overflow)
);

// File: tb/sim_abp_top.sv
module sim_abp_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrOffset = '0;
  logic [3:0]  wrBe = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  lenMode = '0;
  logic        fifoFull = 1'b0;
  logic        pushValid;
  logic [31:0] pushData;
  logic        overflow;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] mStage = '0;
  logic [1:0]  mMode = '0;
  logic        mOvf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  abp_top u0 (.*);

  function automatic int topOf(input logic [1:0] m);
    return (m == 2'b00) ? 1 : (m == 2'b11) ? 3 : 2;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0; fifoFull = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    mStage = '0; mMode = lenMode; mOvf = 1'b0;
  endtask

  // one write; expected results computed from the requirements
  task automatic doWrite(input logic [1:0] off, input logic [3:0] be, input logic [31:0] d,
                         input logic [1:0] m, input bit full, input string req);
    bit complete, expPush;
    logic [31:0] expWord;
    int top;
    @(negedge clk);
    wrEn = 1'b1; wrOffset = off; wrBe = be; wrData = d; lenMode = m; fifoFull = full;
    if (m != mMode) mStage = '0;          // R7
    mMode = m;
    top = topOf(m);
    complete = 0;
    for (int j = 0; j < 4; j++) begin     // R2, R3
      int lane = int'(off) + j;
      if (be[j] && lane < 4 && lane <= top) begin
        mStage[lane*8 +: 8] = d[j*8 +: 8];
        if (lane == top) complete = 1;
      end
    end
    expPush = complete && !full;
    expWord = mStage;
    if (complete) mStage = '0;            // R4
    if (complete && full) mOvf = 1'b1;    // R8
    @(posedge clk); #1;
    check(pushValid == expPush, {req, " R5 push strobe"}, 32'(pushValid), 32'(expPush));
    if (expPush) check(pushData == expWord, {req, " R4 pushed word"}, pushData, expWord);
    check(overflow == mOvf, {req, " R8 overflow"}, 32'(overflow), 32'(mOvf));
    @(negedge clk);
    wrEn = 1'b0; fifoFull = 1'b0;
    @(posedge clk); #1;
    check(pushValid == 1'b0, "R5 single pulse", 32'(pushValid), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [3:0] beSet [4];
    seed = 7;
    void'($urandom(seed));
    beSet[0] = 4'h1; beSet[1] = 4'h3; beSet[2] = 4'h7; beSet[3] = 4'hF;
    doReset();
    #1;
    check(pushValid == 0 && overflow == 0 && pushData == 0, "R9 reset state",
          {pushData[29:0], pushValid, overflow}, 32'h0);

    // R1: 24-bit byte-at-a-time sample pushes on lane 2
    doWrite(2'd0, 4'h1, 32'hAA, 2'b10, 0, "R1 b0");
    doWrite(2'd1, 4'h1, 32'hBB, 2'b10, 0, "R1 b1");
    doWrite(2'd2, 4'h1, 32'hCC, 2'b10, 0, "R1 b2 -> 00CCBBAA");
    // R3: write to lane 3 in 24-bit mode ignored; R4: unwritten lanes zero
    doWrite(2'd3, 4'h1, 32'h5A, 2'b10, 0, "R3 unused lane");
    doWrite(2'd2, 4'h1, 32'h11, 2'b10, 0, "R3/R4 lane2 only -> 00110000");
    // R6: 16-bit mode, 32-bit write drops upper bytes
    doWrite(2'd0, 4'hF, 32'hDEADBEEF, 2'b00, 0, "R6 16-bit -> 0000BEEF");
    // R2: halfword at offset 2 in 32-bit mode completes
    doWrite(2'd0, 4'h3, 32'h2211, 2'b11, 0, "R2 low half");
    doWrite(2'd2, 4'h3, 32'h4433, 2'b11, 0, "R2 high half -> 44332211");
    // R2: overhanging write at offset 3 keeps only its first byte
    doWrite(2'd3, 4'hF, 32'h998877, 2'b11, 0, "R2 overhang -> 77000000");
    // R7: mode change flushes partial word
    doWrite(2'd0, 4'h3, 32'hF0F0, 2'b01, 0, "R7 partial 20-bit");
    doWrite(2'd2, 4'h1, 32'h3C, 2'b10, 0, "R7 new mode -> 003C0000");

    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      m = ($urandom % 8 == 0) ? 2'($urandom) : mMode;
      doWrite(2'($urandom), beSet[$urandom % 4], $urandom, m, 0, "R1 random");
    end

    // R8: full FIFO discards sample and sets sticky overflow
    doWrite(2'd0, 4'h1, 32'h12, 2'b00, 0, "R8 partial");
    doWrite(2'd1, 4'h1, 32'h34, 2'b00, 1, "R8 dropped");
    doWrite(2'd1, 4'h1, 32'h56, 2'b00, 0, "R8 next sample -> 00005600");
    doWrite(2'd0, 4'h3, 32'h7788, 2'b00, 0, "R8 sticky");

    doReset();
    #1;
    check(overflow == 0, "R9 reset clears overflow", 32'(overflow), 32'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule